// File: doc/BRIEF.md
# Six-Channel Timer Cluster with Source Selection

The block groups six down-counting timer channels behind one word-addressed register window. Each channel raises its own interrupt line for one clock when its count reaches zero. Every channel also has a small selector. It picks the channel's count-gate source and its two capture-event sources from a shared 16-bit source vector. The low ten bits of that vector come from chip pins. The top six bits are wired inside the block to the six channel outputs, so a timer can drive another timer in a cascade with no outside wiring.

A single release bit in the shared register area gates counting for all channels at once. Software sets up every channel while the release bit is clear. It then sets the bit, and all armed channels start on the same clock edge.

Bus accesses are whole 32-bit words addressed by word index. Writes take effect at the clock edge where `bus_sel` and `bus_we` are high. Reads are combinational from `bus_addr`.

Top module: `tmr_cluster`

## Requirements
- R1: Each channel counts down by one per count tick. On the tick that moves its count from 1 to 0, its `irq` bit is high for exactly the following cycle. On a tick at count 0 the channel reloads when auto-reload is on, and otherwise stays at 0 with no further pulses.
- R2: Timer i owns words 16*i to 16*i+15. Within that block: offset 0 is control, offset 1 is reload (writing it also loads the count), offset 2 is the current count, offset 3 is capture A, and offset 4 is capture B. Control bits are: bit0 run, bit1 gated mode, bit2 auto-reload.
- R3: Word 96+i (i from 0 to 5) is timer i's source select. Bits [3:0] pick the gate source, bits [7:4] pick the capture A source, and bits [11:8] pick the capture B source, each as an index into the source vector.
- R4: Word 102 bit0 is the global release and resets to 0. While it is clear, no count changes except through a reload write, and no interrupt is raised, whatever each run bit holds.
- R5: With gated mode clear, a running and released channel ticks every clock. With gated mode set, it ticks only on a rising edge of its selected gate source.
- R6: Source vector bits [9:0] are `ext_in`. Bits [15:10] are the six channel outputs, with timer k at bit 10+k, so a channel can count another channel's zero crossings.
- R7: A rising edge on a channel's capture A (or capture B) source copies the current count into capture A (or capture B). Without such an edge, the capture register keeps its value.
- R8: After reset, every register reads 0 and all `irq` bits are low.
- R9: A write to one timer's block changes no other timer's registers. Reads of unmapped words return 0.
- R10: Channels armed before release, with equal reload values, raise their interrupts on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | Write enable (with bus_sel) |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| ext_in | input | 10 | External source inputs, vector bits [9:0] |
| irq | output | 6 | Per-channel zero-crossing interrupt pulses |

## Verification
The bench builds the block with its default parameters: six channels, a 16-bit source vector and 32-bit counters. With these values the fed-back outputs sit at source indices 10 to 15, so a cascade of timer 0 into timer 1 can be set up through registers alone. The 16-word blocks put the shared area at word 96, which lets the bench probe both the boundary between the last timer block and the shared area and the unmapped words past word 102.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NUM_TMR   = 6;
    localparam int EXT_W     = 16;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 16;
    localparam int OFF_W     = $clog2(BLK_WORDS);
    localparam int ADDR_W    = $clog2((NUM_TMR + 1) * BLK_WORDS);
    localparam int SRC_W     = $clog2(EXT_W);
    localparam int EXT_IN_W  = EXT_W - NUM_TMR;

    typedef enum logic [OFF_W-1:0] {
        OFF_CTRL   = 4'd0,
        OFF_RELOAD = 4'd1,
        OFF_COUNT  = 4'd2,
        OFF_CAPA   = 4'd3,
        OFF_CAPB   = 4'd4
    } off_e;

    typedef struct packed {
        logic auto_rl;
        logic gated;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic [SRC_W-1:0] capb;
        logic [SRC_W-1:0] capa;
        logic [SRC_W-1:0] gate;
    } srcsel_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int SEL_W  = $bits(srcsel_t);
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
    import tmr_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_TMR-1:0] tmr_hit,
    output logic               com_hit,
    output logic [OFF_W-1:0]   off
);
    localparam int BLK_IW = ADDR_W - OFF_W;

    logic [BLK_IW-1:0] blk;

    assign blk = addr[ADDR_W-1:OFF_W];
    assign off = addr[OFF_W-1:0];
    assign com_hit = (blk == BLK_IW'(NUM_TMR));

    always_comb begin
        for (int i = 0; i < NUM_TMR; i++) begin
            tmr_hit[i] = (blk == BLK_IW'(i));
        end
    end

    always_comb begin
        assert_one_region_R2: assert ($onehot0({tmr_hit, com_hit}));
    end
endmodule

// File: rtl/tmr_src_mux.sv
module tmr_src_mux
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EXT_W-1:0] src_vec,
    input  srcsel_t          sel,
    output logic             gate_rise,
    output logic             capa_rise,
    output logic             capb_rise
);
    logic [2:0] now_v;
    logic [2:0] prev_q;

    assign now_v = {src_vec[sel.capb], src_vec[sel.capa], src_vec[sel.gate]};

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= now_v;
    end

    assign gate_rise = now_v[0] & ~prev_q[0];
    assign capa_rise = now_v[1] & ~prev_q[1];
    assign capb_rise = now_v[2] & ~prev_q[2];

    assert_gate_edge_R5: assert property (@(posedge clk) disable iff (rst)
        gate_rise |=> !gate_rise || ($past(sel.gate) != sel.gate));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             release_en,
    input  ctrl_t            ctrl,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic             gate_rise,
    input  logic             capa_rise,
    input  logic             capb_rise,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] capa,
    output logic [CNT_W-1:0] capb,
    output logic             zero_pulse
);
    logic tick;

    assign tick = ctrl.run & release_en & (ctrl.gated ? gate_rise : 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count      <= '0;
            reload     <= '0;
            capa       <= '0;
            capb       <= '0;
            zero_pulse <= 1'b0;
        end else begin
            zero_pulse <= 1'b0;
            if (load_we) begin
                reload <= load_val;
                count  <= load_val;
            end else if (tick) begin
                if (count == '0) begin
                    count <= ctrl.auto_rl ? reload : '0;
                end else begin
                    count      <= count - 1'b1;
                    zero_pulse <= (count == CNT_W'(1));
                end
            end
            if (capa_rise) capa <= count;
            if (capb_rise) capb <= count;
        end
    end

    assert_pulse_at_zero_R1: assert property (@(posedge clk) disable iff (rst)
        zero_pulse |-> (count == '0));
    assert_pulse_single_R1: assert property (@(posedge clk) disable iff (rst)
        zero_pulse |=> !zero_pulse);
    assert_hold_unreleased_R4: assert property (@(posedge clk) disable iff (rst)
        (!release_en && !load_we) |=> $stable(count));
    assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
        load_we |=> (count == $past(load_val)));
    assert_capa_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !capa_rise |=> $stable(capa));
    assert_capb_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !capb_rise |=> $stable(capb));
endmodule

// File: rtl/tmr_cluster.sv
module tmr_cluster
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [EXT_IN_W-1:0] ext_in,
    output logic [NUM_TMR-1:0]  irq
);
    localparam logic [OFF_W-1:0] GO_OFF = OFF_W'(NUM_TMR);

    logic [NUM_TMR-1:0] tmr_hit;
    logic               com_hit;
    logic [OFF_W-1:0]   off;
    logic               wr;
    logic               go_q;
    logic [EXT_W-1:0]   src_vec;

    ctrl_t              ctrl_q   [NUM_TMR];
    srcsel_t            sel_q    [NUM_TMR];
    logic [NUM_TMR-1:0] load_we;
    logic [NUM_TMR-1:0] gate_rise, capa_rise, capb_rise;
    logic [CNT_W-1:0]   cnt_w    [NUM_TMR];
    logic [CNT_W-1:0]   rld_w    [NUM_TMR];
    logic [CNT_W-1:0]   capa_w   [NUM_TMR];
    logic [CNT_W-1:0]   capb_w   [NUM_TMR];

    assign wr      = bus_sel & bus_we;
    assign src_vec = {irq, ext_in};

    tmr_addr_dec u_dec (
        .addr    (bus_addr),
        .tmr_hit (tmr_hit),
        .com_hit (com_hit),
        .off     (off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q <= 1'b0;
            for (int i = 0; i < NUM_TMR; i++) begin
                ctrl_q[i] <= '0;
                sel_q[i]  <= '0;
            end
        end else if (wr) begin
            if (com_hit && off == GO_OFF) go_q <= bus_wdata[0];
            for (int i = 0; i < NUM_TMR; i++) begin
                if (tmr_hit[i] && off == OFF_CTRL)
                    ctrl_q[i] <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
                if (com_hit && off == OFF_W'(i))
                    sel_q[i] <= srcsel_t'(bus_wdata[SEL_W-1:0]);
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_TMR; g++) begin : g_ch
            assign load_we[g] = wr & tmr_hit[g] & (off == OFF_RELOAD);

            tmr_src_mux u_mux (
                .clk       (clk),
                .rst       (rst),
                .src_vec   (src_vec),
                .sel       (sel_q[g]),
                .gate_rise (gate_rise[g]),
                .capa_rise (capa_rise[g]),
                .capb_rise (capb_rise[g])
            );

            tmr_channel #(.CNT_W(CNT_W)) u_ch (
                .clk        (clk),
                .rst        (rst),
                .release_en (go_q),
                .ctrl       (ctrl_q[g]),
                .load_we    (load_we[g]),
                .load_val   (bus_wdata[CNT_W-1:0]),
                .gate_rise  (gate_rise[g]),
                .capa_rise  (capa_rise[g]),
                .capb_rise  (capb_rise[g]),
                .count      (cnt_w[g]),
                .reload     (rld_w[g]),
                .capa       (capa_w[g]),
                .capb       (capb_w[g]),
                .zero_pulse (irq[g])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (tmr_hit[i]) begin
                case (off)
                    OFF_CTRL:   bus_rdata = WORD_W'(ctrl_q[i]);
                    OFF_RELOAD: bus_rdata = WORD_W'(rld_w[i]);
                    OFF_COUNT:  bus_rdata = WORD_W'(cnt_w[i]);
                    OFF_CAPA:   bus_rdata = WORD_W'(capa_w[i]);
                    OFF_CAPB:   bus_rdata = WORD_W'(capb_w[i]);
                    default:    bus_rdata = '0;
                endcase
            end
            if (com_hit && off == OFF_W'(i)) bus_rdata = WORD_W'(sel_q[i]);
        end
        if (com_hit && off == GO_OFF) bus_rdata = WORD_W'(go_q);
    end

    assert_quiet_unreleased_R4: assert property (@(posedge clk) disable iff (rst)
        !go_q |=> (irq == '0));
    assert_reset_quiet_R8: assert property (@(posedge clk)
        $past(rst) |-> (irq == '0));
endmodule

// File: tb/sim_tmr_cluster.sv
module sim_tmr_cluster;
    import tmr_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                bus_sel = 1'b0;
    logic                bus_we = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [WORD_W-1:0]   bus_wdata = '0;
    logic [WORD_W-1:0]   bus_rdata;
    logic [EXT_IN_W-1:0] ext_in = '0;
    logic [NUM_TMR-1:0]  irq;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    tmr_cluster u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_in    (ext_in),
        .irq       (irq)
    );

    // {write, addr[6:0], wdata[31:0], expected read[31:0]}; tags R2 R3 R9
    localparam int NROWS = 14;
    localparam logic [71:0] TBL [NROWS] = '{
        {1'b1, 7'd1,   32'h25,  32'h0},
        {1'b0, 7'd2,   32'h0,   32'h25},
        {1'b1, 7'd17,  32'h7,   32'h0},
        {1'b0, 7'd2,   32'h0,   32'h25},
        {1'b0, 7'd18,  32'h0,   32'h7},
        {1'b1, 7'd16,  32'hFF,  32'h0},
        {1'b0, 7'd16,  32'h0,   32'h7},
        {1'b0, 7'd0,   32'h0,   32'h0},
        {1'b1, 7'd97,  32'hFABC,32'h0},
        {1'b0, 7'd97,  32'h0,   32'hABC},
        {1'b0, 7'd96,  32'h0,   32'h0},
        {1'b0, 7'd7,   32'h0,   32'h0},
        {1'b0, 7'd110, 32'h0,   32'h0},
        {1'b0, 7'd120, 32'h0,   32'h0}
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1;
        bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = ADDR_W'(a);
        #1 d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #800000;
        checks++; failures++;
        $display("FAIL R1 watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int np0, np1, first4, mism;
        do_reset();

        // R8 reset state
        @(negedge clk);
        rd(2, v);   chk(v == 0, "R8 count", v, 0);
        rd(102, v); chk(v == 0, "R8 release", v, 0);
        rd(99, v);  chk(v == 0, "R8 select", v, 0);
        chk(irq == 0, "R8 irq", irq, 0);

        // table walk: R2 R3 R9
        for (int i = 0; i < NROWS; i++) begin
            if (TBL[i][71]) wr(int'(TBL[i][70:64]), TBL[i][63:32]);
            else begin
                @(negedge clk);
                rd(int'(TBL[i][70:64]), v);
                if (v != TBL[i][31:0])
                    $display("FAIL R2/R3/R9 table row %0d", i);
                chk(v == TBL[i][31:0], "R2 R3 R9 table", v, TBL[i][31:0]);
            end
        end

        // cascade and gating: R4 R5 R6
        do_reset();
        wr(1, 1);  wr(0, 5);
        wr(17, 2); wr(16, 3); wr(97, 32'h00A);
        wr(33, 4); wr(32, 3); wr(98, 32'h000);
        repeat (3) @(negedge clk);
        rd(2, v);  chk(v == 1, "R4 hold before release", v, 1);
        chk(irq == 0, "R4 no irq before release", irq, 0);
        wr(102, 1);
        np1 = 0; np0 = 0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (irq[1]) np1++;
            if (irq[0]) np0++;
        end
        rd(18, v); chk(v == 0, "R6 cascade count", v, 0);
        chk(np1 == 1, "R6 cascade irq pulses", np1, 1);
        chk(np0 > 5, "R1 auto-reload pulses", np0, 6);
        rd(34, v); chk(v == 4, "R5 gated idle", v, 4);
        for (int t = 0; t < 3; t++) begin
            @(negedge clk); ext_in[0] = 1'b1;
            @(negedge clk); ext_in[0] = 1'b0;
        end
        @(negedge clk);
        rd(34, v); chk(v == 1, "R5 gated edges", v, 1);
        wr(102, 0);
        @(negedge clk);
        rd(2, v);
        repeat (5) @(negedge clk);
        rd(2, v2); chk(v == v2, "R4 frozen after clear", v2, v);

        // synchronous release and capture: R1 R7 R10
        do_reset();
        wr(65, 5); wr(64, 1);
        repeat (4) @(negedge clk);
        wr(81, 5); wr(80, 1);
        wr(49, 200); wr(48, 1); wr(99, 32'h210);
        wr(102, 1);
        first4 = -1; mism = 0; np0 = 0;
        for (int c = 1; c <= 10; c++) begin
            @(negedge clk);
            if (irq[4] != irq[5]) mism++;
            if (irq[4]) begin np0++; if (first4 < 0) first4 = c; end
        end
        chk(mism == 0, "R10 aligned irq", mism, 0);
        chk(first4 == 5, "R1 zero cycle", first4, 5);
        chk(np0 == 1, "R1 single pulse no reload", np0, 1);
        rd(66, v); chk(v == 0, "R1 held at zero", v, 0);
        @(negedge clk);
        ext_in[1] = 1'b1;
        rd(50, v);
        @(negedge clk);
        ext_in[1] = 1'b0;
        rd(51, v2); chk(v2 == v, "R7 capture A", v2, v);
        rd(52, v2); chk(v2 == 0, "R7 capture B untouched", v2, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule